// File: doc/BRIEF.md
# Dock Instruction Sequencer

This block runs the instruction stream of one port of a switch-fabric processor. It takes one 26-bit instruction at a time from an instruction queue and decodes its flag byte into a series of actions. Depending on the flags, the block waits for an input packet, captures a data word, sends a data packet, sends a token packet, or loads a sign-extended literal into its 37-bit data register. Every handshake is valid/ready, and the actions run one after another: input first, then capture, then output.

Each instruction carries a 7-bit loop count. When an execution finishes, the block checks the count. A count of zero retires the instruction. Any other count is decremented and the instruction runs again, unless the count is all ones, which marks a standing instruction that keeps its count. A requeue flag selects how the next run happens: the block either starts the next run at once or hands the updated word back on a push port so it can rejoin the queue tail. The block also decodes kill, clog and unclog encodings and three illegal flag pairs.

Top module: `dock_seq`

## Requirements
- R1: After a synchronous reset, the block accepts instructions (`ins_ready`=1), holds `in_ready`, `out_valid` and `rq_valid` low, and holds `err` low.
- R2: Instruction layout: [25] kill, [24] literal, [23] token-in, [22] data-in, [21] capture, [20] data-out, [19] token-out, [18] requeue, [17:11] count, [10:0] destination. An instruction with kill set is consumed and does nothing: no packet, no requeue, and the block is idle again on the next cycle.
- R3: An instruction with literal set (and kill clear) sign-extends bits [10:0] to 37 bits and loads the result into the data register. Its other action flags are ignored. Its count and requeue bits still apply.
- R4: Token-in and data-in each accept exactly one input packet. Data-in with capture set loads bits [36:0] of that packet into the data register, but only when packet bit 48 (token flag) is 0.
- R5: Output packet layout: bit 48 token flag, [47:36+1] destination taken from the instruction, [36:0] word. Data-out sends {0, dest, data register}. Token-out sends {1, dest, 0}. While `out_ready` is low, the packet stays valid and unchanged.
- R6: The phases of one execution run in the order token-in, data-in, data-out, token-out. `in_ready` and `out_valid` are never high together.
- R7: With requeue clear, an instruction with count N (N < 127) executes N+1 times and is then retired. Count 0 executes once.
- R8: With requeue set and a nonzero count, the block presents the instruction with its count decremented on `rq_word`. It holds that word stable until `rq_ready`, then goes idle.
- R9: Count 127 is a standing value that is never decremented. A requeued standing instruction keeps count 127.
- R10: A clog is count 127 with kill, literal and all five action flags clear. It parks the block. While parked, only an unclog (kill=1 and token-in=1) is accepted, and the unclog releases the block.
- R11: Three flag pairs are illegal: capture without data-in, token-in with data-in on an input dock, and token-out with data-out on an output dock. An illegal instruction sets the sticky `err` output and then runs as a nop under the normal count rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction offered by the queue |
| ins_ready | output | 1 | Instruction accepted |
| ins_word | input | 26 | Instruction word |
| in_valid | input | 1 | Input packet offered |
| in_ready | output | 1 | Input packet accepted |
| in_pkt | input | 49 | Input packet |
| out_valid | output | 1 | Output packet offered |
| out_ready | input | 1 | Output packet accepted |
| out_pkt | output | 49 | Output packet |
| rq_valid | output | 1 | Instruction pushed back to the queue |
| rq_ready | input | 1 | Push accepted |
| rq_word | output | 26 | Instruction with updated count |
| err | output | 1 | Sticky illegal-instruction flag |

## Verification
The assertions watch the following on every cycle:
- output and requeue words stay stable under backpressure;
- token packets carry a zero word;
- input and output phases never overlap;
- an idle block is quiet;
- a kill returns the block to idle;
- a parked clog refuses everything except an unclog;
- the error flag stays set once raised.

Other behaviours show only in the bench's scenarios, which a reference model checks packet by packet:
- the number of executions each count produces;
- the decremented or standing count in a requeued word;
- sign extension of literals;
- capture being suppressed for token-flagged input;
- illegal instructions running as nops.

// File: rtl/dock_seq_pkg.sv
package dock_seq_pkg;

    localparam int WORD_W = 37;
    localparam int ADDR_W = 11;
    localparam int CNT_W  = 7;
    localparam int FLAG_W = 8;
    localparam int INS_W  = FLAG_W + CNT_W + ADDR_W;
    localparam int PKT_W  = 1 + ADDR_W + WORD_W;
    localparam logic [CNT_W-1:0] CNT_STANDING = '1;

    typedef struct packed {
        logic kill;
        logic lit;
        logic ti;
        logic di;
        logic dc;
        logic dout;
        logic tout;
        logic rq;
    } flags_t;

    typedef struct packed {
        flags_t             f;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  dest;
    } ins_t;

    typedef struct packed {
        logic               tok;
        logic [ADDR_W-1:0]  dest;
        logic [WORD_W-1:0]  word;
    } pkt_t;

    typedef struct packed {
        logic is_kill;
        logic is_unclog;
        logic is_lit;
        logic is_clog;
        logic illegal;
        logic ti;
        logic di;
        logic dc;
        logic dout;
        logic tout;
    } dec_t;

    typedef enum logic [2:0] {
        S_IDLE, S_TIN, S_DIN, S_DOUT, S_TOUT, S_FIN, S_RQ, S_CLOG
    } st_t;

    function automatic logic [WORD_W-1:0] lit_ext(input logic [ADDR_W-1:0] v);
        return {{(WORD_W-ADDR_W){v[ADDR_W-1]}}, v};
    endfunction

    // Next action phase after phase s; S_FIN when none remain.
    function automatic st_t next_phase(input dec_t d, input st_t s);
        logic past_ti, past_di, past_do;
        past_ti = (s == S_TIN) || (s == S_DIN) || (s == S_DOUT) || (s == S_TOUT);
        past_di = (s == S_DIN) || (s == S_DOUT) || (s == S_TOUT);
        past_do = (s == S_DOUT) || (s == S_TOUT);
        if (d.ti && !past_ti)   return S_TIN;
        if (d.di && !past_di)   return S_DIN;
        if (d.dout && !past_do) return S_DOUT;
        if (d.tout && s != S_TOUT) return S_TOUT;
        return S_FIN;
    endfunction

endpackage

// File: rtl/dock_decode.sv
module dock_decode
    import dock_seq_pkg::*;
#(
    parameter bit IN_DOCK  = 1'b1,
    parameter bit OUT_DOCK = 1'b1
) (
    input  ins_t ins,
    output dec_t dec
);
    logic any_act;

    always_comb begin
        dec     = '0;
        any_act = ins.f.ti | ins.f.di | ins.f.dc | ins.f.dout | ins.f.tout;
        if (ins.f.kill) begin
            dec.is_kill   = 1'b1;
            dec.is_unclog = ins.f.ti;
        end else if (ins.f.lit) begin
            dec.is_lit = 1'b1;
        end else begin
            dec.illegal = (ins.f.dc && !ins.f.di)
                        || (IN_DOCK  && ins.f.ti   && ins.f.di)
                        || (OUT_DOCK && ins.f.tout && ins.f.dout);
            dec.is_clog = (ins.cnt == CNT_STANDING) && !any_act;
            if (!dec.illegal) begin
                dec.ti   = ins.f.ti;
                dec.di   = ins.f.di;
                dec.dc   = ins.f.dc;
                dec.dout = ins.f.dout;
                dec.tout = ins.f.tout;
            end
        end
    end
endmodule

// File: rtl/dock_count_step.sv
module dock_count_step
    import dock_seq_pkg::*;
(
    input  logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic [CNT_W-1:0] cnt_nxt
);
    assign expire  = (cnt == '0);
    assign cnt_nxt = (cnt == CNT_STANDING) ? cnt
                   : cnt - {{(CNT_W-1){1'b0}}, 1'b1};
endmodule

// File: rtl/dock_pkt_build.sv
module dock_pkt_build
    import dock_seq_pkg::*;
(
    input  logic              tok,
    input  logic [ADDR_W-1:0] dest,
    input  logic [WORD_W-1:0] data,
    output pkt_t              pkt
);
    always_comb begin
        pkt.tok  = tok;
        pkt.dest = dest;
        pkt.word = tok ? '0 : data;
    end
endmodule

// File: rtl/dock_seq.sv
module dock_seq
    import dock_seq_pkg::*;
#(
    parameter bit IN_DOCK  = 1'b1,
    parameter bit OUT_DOCK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_valid,
    output logic             ins_ready,
    input  logic [INS_W-1:0] ins_word,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PKT_W-1:0] out_pkt,
    output logic             rq_valid,
    input  logic             rq_ready,
    output logic [INS_W-1:0] rq_word,
    output logic             err
);
    st_t               st_q;
    ins_t              cur_q;
    logic [WORD_W-1:0] data_q;
    logic              err_q;

    ins_t              ins_in;
    ins_t              dec_src;
    dec_t              dec;
    pkt_t              out_p;
    logic              expire;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              in_tok;
    logic [WORD_W-1:0] in_word;
    logic              unused_in_dest;

    assign ins_in         = ins_t'(ins_word);
    assign in_tok         = in_pkt[PKT_W-1];
    assign in_word        = in_pkt[WORD_W-1:0];
    assign unused_in_dest = ^in_pkt[PKT_W-2:WORD_W];
    assign dec_src        = (st_q == S_IDLE || st_q == S_CLOG) ? ins_in : cur_q;

    dock_decode #(.IN_DOCK(IN_DOCK), .OUT_DOCK(OUT_DOCK)) u_dec (
        .ins (dec_src),
        .dec (dec)
    );

    dock_count_step u_cnt (
        .cnt     (cur_q.cnt),
        .expire  (expire),
        .cnt_nxt (cnt_nxt)
    );

    dock_pkt_build u_pkt (
        .tok  (st_q == S_TOUT),
        .dest (cur_q.dest),
        .data (data_q),
        .pkt  (out_p)
    );

    assign ins_ready = (st_q == S_IDLE) || (st_q == S_CLOG && ins_valid && dec.is_unclog);
    assign in_ready  = (st_q == S_TIN) || (st_q == S_DIN);
    assign out_valid = (st_q == S_DOUT) || (st_q == S_TOUT);
    assign out_pkt   = out_p;
    assign rq_valid  = (st_q == S_RQ);
    assign rq_word   = cur_q;
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            cur_q  <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                S_IDLE: if (ins_valid && !dec.is_kill) begin
                    cur_q <= ins_in;
                    if (dec.illegal) err_q <= 1'b1;
                    st_q <= dec.is_clog ? S_CLOG : next_phase(dec, S_IDLE);
                end
                S_TIN: if (in_valid) st_q <= next_phase(dec, S_TIN);
                S_DIN: if (in_valid) begin
                    if (dec.dc && !in_tok) data_q <= in_word;
                    st_q <= next_phase(dec, S_DIN);
                end
                S_DOUT: if (out_ready) st_q <= next_phase(dec, S_DOUT);
                S_TOUT: if (out_ready) st_q <= S_FIN;
                S_FIN: begin
                    if (dec.is_lit) data_q <= lit_ext(cur_q.dest);
                    if (expire) begin
                        st_q <= S_IDLE;
                    end else begin
                        cur_q.cnt <= cnt_nxt;
                        st_q <= cur_q.f.rq ? S_RQ : next_phase(dec, S_FIN);
                    end
                end
                S_RQ:   if (rq_ready) st_q <= S_IDLE;
                S_CLOG: if (ins_valid && dec.is_unclog) st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R1: an idle block drives nothing
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE) |-> (!out_valid && !rq_valid && !in_ready));

    // R2: a kill leaves the block idle
    assert_kill_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_IDLE && ins_valid && ins_word[INS_W-1]) |=> (st_q == S_IDLE));

    // R5: output held under backpressure
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pkt)));

    // R5: token packets carry a zero word
    assert_tok_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_pkt[PKT_W-1]) |-> (out_pkt[WORD_W-1:0] == '0));

    // R6: input and output phases never overlap
    assert_phase_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R8: requeue word held under backpressure
    assert_rq_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_word)));

    // R10: a parked clog refuses anything but an unclog
    assert_clog_block_R10: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_CLOG && !(ins_word[INS_W-1] && ins_word[INS_W-3])) |-> !ins_ready);

    // R11: error flag is sticky
    assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: tb/dock_seq_tb_top.sv
module dock_seq_tb_top;
    localparam logic [7:0] F_K  = 8'h80;
    localparam logic [7:0] F_L  = 8'h40;
    localparam logic [7:0] F_TI = 8'h20;
    localparam logic [7:0] F_DI = 8'h10;
    localparam logic [7:0] F_DC = 8'h08;
    localparam logic [7:0] F_DO = 8'h04;
    localparam logic [7:0] F_TO = 8'h02;
    localparam logic [7:0] F_RQ = 8'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [25:0] ins_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [48:0] in_pkt = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [48:0] out_pkt;
    logic        rq_valid;
    logic        rq_ready = 1'b1;
    logic [25:0] rq_word;
    logic        err;

    int checks = 0;
    int failures = 0;
    logic [48:0] in_q[$];
    logic [48:0] exp_out[$];
    logic [25:0] exp_rq[$];
    logic        in_pop = 1'b0;
    logic [48:0] e_pkt;
    logic [25:0] e_rq;

    always #5 clk = ~clk;

    dock_seq dut_i (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word),
        .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
        .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_word(rq_word),
        .err(err)
    );

    function automatic logic [25:0] mk(input logic [7:0] f, input int c, input logic [10:0] d);
        return {f, c[6:0], d};
    endfunction

    function automatic logic [48:0] pk(input logic t, input logic [10:0] d, input logic [36:0] w);
        return {t, d, w};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Reference model: input supply and packet-by-packet comparison on every clock
    initial begin
        forever begin
            @(negedge clk);
            if (in_pop) begin
                void'(in_q.pop_front());
                in_pop = 1'b0;
            end
            if (in_q.size() > 0) begin
                in_valid = 1'b1;
                in_pkt   = in_q[0];
            end else begin
                in_valid = 1'b0;
                in_pkt   = '0;
            end
            #1;
            if (!rst) begin
                if (in_valid && in_ready) in_pop = 1'b1;
                if (out_valid && out_ready) begin
                    if (exp_out.size() == 0) begin
                        chk(1'b0, "R5 unexpected output packet", out_pkt, 0);
                    end else begin
                        e_pkt = exp_out.pop_front();
                        chk(out_pkt == e_pkt, "R5 output packet", out_pkt, e_pkt);
                    end
                end
                if (rq_valid && rq_ready) begin
                    if (exp_rq.size() == 0) begin
                        chk(1'b0, "R8 unexpected requeue", rq_word, 0);
                    end else begin
                        e_rq = exp_rq.pop_front();
                        chk(rq_word == e_rq, "R8 requeue word", rq_word, e_rq);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_q.delete();
        exp_out.delete();
        exp_rq.delete();
        in_pop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send_ins(input logic [25:0] w);
        @(negedge clk);
        ins_valid = 1'b1;
        ins_word  = w;
        #1;
        while (!ins_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        ins_valid = 1'b0;
    endtask

    task automatic drain(input string req, input bit expect_idle);
        int t = 0;
        while ((exp_out.size() > 0 || exp_rq.size() > 0 || in_q.size() > 0) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
        #2;
        chk(exp_out.size() == 0 && exp_rq.size() == 0 && in_q.size() == 0, req,
            exp_out.size() + exp_rq.size() + in_q.size(), 0);
        if (expect_idle) chk(ins_ready == 1'b1, req, ins_ready, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        // R1 reset state
        chk(ins_ready == 1'b1, "R1 ins_ready after reset", ins_ready, 1);
        chk(!out_valid && !rq_valid && !in_ready, "R1 quiet after reset",
            {out_valid, rq_valid, in_ready}, 0);
        chk(err == 1'b0, "R1 err after reset", err, 0);

        // R3 literal, negative and with data-out flag ignored
        send_ins(mk(F_L, 0, 11'h7FB));
        exp_out.push_back(pk(1'b0, 11'h012, 37'h1F_FFFF_FFFB));
        send_ins(mk(F_DO, 0, 11'h012));
        drain("R3 negative literal sign-extended", 1'b1);
        send_ins(mk(F_L | F_DO | F_TO, 0, 11'h155));
        drain("R3 literal skips other actions", 1'b1);
        exp_out.push_back(pk(1'b0, 11'h013, 37'h155));
        send_ins(mk(F_DO, 0, 11'h013));
        drain("R3 positive literal loaded", 1'b1);

        // R7 count 2 gives three tokens
        for (int i = 0; i < 3; i++) exp_out.push_back(pk(1'b1, 11'h03A, '0));
        send_ins(mk(F_TO, 2, 11'h03A));
        drain("R7 count 2 runs three times", 1'b1);

        // R4 capture from data packet
        in_q.push_back(pk(1'b0, 11'h000, 37'h1_2345_6789));
        send_ins(mk(F_DI | F_DC, 0, 11'h000));
        drain("R4 data-in consumes one packet", 1'b1);
        exp_out.push_back(pk(1'b0, 11'h005, 37'h1_2345_6789));
        send_ins(mk(F_DO, 0, 11'h005));
        drain("R4 captured word emitted", 1'b1);

        // R4 token-flagged packet is not captured
        in_q.push_back(pk(1'b1, 11'h000, 37'h0_0000_AAAA));
        send_ins(mk(F_DI | F_DC, 0, 11'h000));
        exp_out.push_back(pk(1'b0, 11'h006, 37'h1_2345_6789));
        send_ins(mk(F_DO, 0, 11'h006));
        drain("R4 token flag blocks capture", 1'b1);

        // R4 token-in consumes one packet
        in_q.push_back(pk(1'b1, 11'h000, '0));
        send_ins(mk(F_TI, 0, 11'h000));
        drain("R4 token-in consumes one packet", 1'b1);

        // R6 input then output, twice
        in_q.push_back(pk(1'b0, 11'h000, 37'h0_0000_0001));
        in_q.push_back(pk(1'b0, 11'h000, 37'h0_0000_0002));
        exp_out.push_back(pk(1'b0, 11'h021, 37'h1_2345_6789));
        exp_out.push_back(pk(1'b0, 11'h021, 37'h1_2345_6789));
        send_ins(mk(F_DI | F_DO, 1, 11'h021));
        drain("R6 input before output per run", 1'b1);

        // R8 requeue with decrement
        exp_out.push_back(pk(1'b1, 11'h007, '0));
        exp_rq.push_back(mk(F_TO | F_RQ, 2, 11'h007));
        send_ins(mk(F_TO | F_RQ, 3, 11'h007));
        drain("R8 requeue decremented count", 1'b1);

        // R9 standing count kept on requeue
        exp_out.push_back(pk(1'b1, 11'h008, '0));
        exp_rq.push_back(mk(F_TO | F_RQ, 127, 11'h008));
        send_ins(mk(F_TO | F_RQ, 127, 11'h008));
        drain("R9 standing count unchanged", 1'b1);

        // R7 count 0 with requeue: retired, no push
        exp_out.push_back(pk(1'b1, 11'h00A, '0));
        send_ins(mk(F_TO | F_RQ, 0, 11'h00A));
        drain("R7 count 0 retired", 1'b1);

        // R8 requeue held under backpressure
        rq_ready = 1'b0;
        exp_out.push_back(pk(1'b1, 11'h00B, '0));
        exp_rq.push_back(mk(F_TO | F_RQ, 0, 11'h00B));
        send_ins(mk(F_TO | F_RQ, 1, 11'h00B));
        repeat (6) @(negedge clk);
        #2;
        chk(rq_valid && rq_word == mk(F_TO | F_RQ, 0, 11'h00B), "R8 requeue held", rq_word,
            mk(F_TO | F_RQ, 0, 11'h00B));
        @(negedge clk);
        rq_ready = 1'b1;
        drain("R8 requeue released", 1'b1);

        // R2 kill does nothing
        send_ins(mk(F_K | F_TO | F_RQ, 5, 11'h00C));
        drain("R2 kill emits nothing", 1'b1);
        exp_out.push_back(pk(1'b1, 11'h001, '0));
        send_ins(mk(F_TO, 0, 11'h001));
        drain("R2 block usable after kill", 1'b1);

        // R5 stall keeps packet stable
        out_ready = 1'b0;
        exp_out.push_back(pk(1'b1, 11'h009, '0));
        send_ins(mk(F_TO, 0, 11'h009));
        repeat (3) @(negedge clk);
        #2;
        chk(out_valid && out_pkt == pk(1'b1, 11'h009, '0), "R5 packet held under stall",
            out_pkt, pk(1'b1, 11'h009, '0));
        @(negedge clk);
        out_ready = 1'b1;
        drain("R5 stalled packet delivered", 1'b1);

        // R10 clog parks, unclog releases
        send_ins(mk(8'h00, 127, 11'h000));
        @(negedge clk);
        ins_valid = 1'b1;
        ins_word  = mk(F_TO, 0, 11'h003);
        for (int i = 0; i < 4; i++) begin
            #1;
            chk(ins_ready == 1'b0 && out_valid == 1'b0, "R10 clog refuses other instruction",
                ins_ready, 0);
            @(negedge clk);
        end
        ins_word = mk(F_K | F_TI, 0, 11'h000);
        #1;
        chk(ins_ready == 1'b1, "R10 unclog accepted", ins_ready, 1);
        @(negedge clk);
        ins_valid = 1'b0;
        exp_out.push_back(pk(1'b1, 11'h002, '0));
        send_ins(mk(F_TO, 0, 11'h002));
        drain("R10 block released by unclog", 1'b1);

        // R11 illegal combinations
        chk(err == 1'b0, "R11 err clear before illegal", err, 0);
        send_ins(mk(F_DC, 0, 11'h000));
        drain("R11 capture-only runs as nop", 1'b1);
        chk(err == 1'b1, "R11 err set by capture without data-in", err, 1);
        exp_out.push_back(pk(1'b1, 11'h004, '0));
        send_ins(mk(F_TO, 0, 11'h004));
        drain("R11 later instruction still runs", 1'b1);
        chk(err == 1'b1, "R11 err sticky", err, 1);

        do_reset();
        send_ins(mk(F_TI | F_DI, 0, 11'h000));
        drain("R11 token-in with data-in is nop", 1'b1);
        chk(err == 1'b1, "R11 err set by token-in with data-in", err, 1);

        do_reset();
        send_ins(mk(F_TO | F_DO, 1, 11'h00D));
        drain("R11 token-out with data-out emits nothing", 1'b1);
        chk(err == 1'b1, "R11 err set by token-out with data-out", err, 1);

        finish_run();
    end
endmodule